// File: doc/BRIEF.md
# Panel Power Sequencer with Three-Wire Register Writer

This block brings a small display panel up and down by writing its control registers over a three-wire serial link. The link has an active-low frame enable, a serial clock and a data line. The link is write-only. Each transfer is one 16-bit frame: a register address followed by the value to store there. The bits go out most-significant first. The panel takes each bit on the rising edge of the serial clock.

Two single-cycle command inputs choose a built-in script. The power-up command plays five register writes in a fixed order. The power-down command plays one write. While a script runs, `busy` is high and any new command is dropped. When the last frame closes, `done` pulses for one cycle.

The parameter `DIV` sets the serial timing. Each low phase and each high phase of the serial clock lasts `DIV` system cycles. Frames inside one script are separated by a fixed idle gap.

Top module: `panel_pwr_seq`

## Requirements
- R1: Each frame carries 16 bits, most-significant bit first. Bits 15..8 are the register address and bits 7..0 are the value.
- R2: After reset, and whenever no script is running, the enable line is high, the serial clock is high and the data line is low. In that state `busy` and `done` are both low.
- R3: A frame opens when the enable line falls while the serial clock is high and the data line is low. This opening state lasts `DIV` cycles, then the first clock low phase begins.
- R4: For each bit, the serial clock is first low for exactly `DIV` cycles, with the data line already showing the bit. The clock is then high for exactly `DIV` cycles. The data line does not change while the clock is high inside a frame.
- R5: The enable line returns high at the end of the sixteenth high phase. At that moment the serial clock is high and the data line is low.
- R6: The power-up command writes these pairs (address, value), in this order: (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F).
- R7: The power-down command writes the single pair (0x05,0x5E).
- R8: A command that arrives while `busy` is low is accepted, and `busy` is high on the next cycle. If both commands arrive in the same cycle, power-up is taken.
- R9: A command that arrives while `busy` is high is ignored. It causes no frame and no `done` pulse.
- R10: Between two consecutive frames of one script, the enable line stays high for exactly 2*DIV+1 cycles. Between frames of different scripts, it stays high for at least that long.
- R11: `done` is a one-cycle pulse. It rises in the same cycle that the enable line rises after the last frame, and `busy` falls in that cycle too. Count from the accepting clock edge to the edge that raises `done`, with the shifter idle at acceptance and N frames in the script. That count is 1 + (N-1)*(35*DIV+1) + 33*DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | One-cycle request to run the power-up script |
| cmd_off | input | 1 | One-cycle request to run the power-down script |
| busy | output | 1 | High while a script is running |
| done | output | 1 | One-cycle pulse when a script finishes |
| ser_en_n | output | 1 | Active-low frame enable |
| ser_clk | output | 1 | Serial clock; the panel samples on its rising edge |
| ser_dat | output | 1 | Serial data |

## Verification
`busy` is due one cycle after the command is sampled. `done` is due at the latency in R11, counted in clock edges from the edge where the command is accepted. The bench counts cycles on a free-running counter and samples on the falling clock edge. It compares the exact cycle number where `done` appears with the value computed from R11.

The frame contents, the phase lengths and the inter-frame gaps are measured at the pins by a monitor, one falling edge at a time. Each phase and gap must end at exactly the cycle that R3, R4 and R10 require, so a phase that is one cycle long or short is reported.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    SH_IDLE = 3'd0,
    SH_OPEN = 3'd1,
    SH_LOW  = 3'd2,
    SH_HIGH = 3'd3,
    SH_GAP  = 3'd4
  } sh_state_t;

  localparam int FRAME_BITS  = 16;
  localparam int SCRIPT_LEN  = 6;
  localparam int IDX_W       = 3;
  localparam logic [IDX_W-1:0] UP_FIRST = 3'd0;
  localparam logic [IDX_W-1:0] UP_LAST  = 3'd4;
  localparam logic [IDX_W-1:0] DN_FIRST = 3'd5;
  localparam logic [IDX_W-1:0] DN_LAST  = 3'd5;

  // Script store: power-up entries at 0..4, power-down entry at 5.
  function automatic logic [FRAME_BITS-1:0] script_word(input logic [IDX_W-1:0] idx);
    logic [FRAME_BITS-1:0] w;
    case (idx)
      3'd0:    w = {8'h05, 8'h1E};
      3'd1:    w = {8'h05, 8'h5E};
      3'd2:    w = {8'h07, 8'h8D};
      3'd3:    w = {8'h13, 8'h01};
      3'd4:    w = {8'h05, 8'h5F};
      3'd5:    w = {8'h05, 8'h5E};
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pps_phase_timer.sv
module pps_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len_m1,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = len_m1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // A load always restarts the count from the requested length.
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(len_m1)));

endmodule

// File: rtl/pps_shifter.sv
module pps_shifter
  import pps_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  ready,
  output logic                  frame_end,
  output logic                  ser_en_n,
  output logic                  ser_clk,
  output logic                  ser_dat
);
  localparam int CW = $clog2(2*DIV + 1);
  localparam logic [CW-1:0] PH_M1  = CW'(DIV - 1);
  localparam logic [CW-1:0] GAP_M1 = CW'(2*DIV - 1);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  sh_state_t             st_q, st_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [BW-1:0]         bc_q, bc_d;
  logic                  t_load, t_zero;
  logic [CW-1:0]         t_len;

  pps_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (t_load),
    .len_m1 (t_len),
    .zero   (t_zero)
  );

  always_comb begin
    st_d      = st_q;
    sr_d      = sr_q;
    bc_d      = bc_q;
    t_load    = 1'b0;
    t_len     = PH_M1;
    frame_end = 1'b0;
    case (st_q)
      SH_IDLE: if (start) begin
        st_d   = SH_OPEN;
        sr_d   = word;
        bc_d   = '0;
        t_load = 1'b1;
      end
      SH_OPEN: if (t_zero) begin
        st_d   = SH_LOW;
        t_load = 1'b1;
      end
      SH_LOW: if (t_zero) begin
        st_d   = SH_HIGH;
        t_load = 1'b1;
      end
      SH_HIGH: if (t_zero) begin
        t_load = 1'b1;
        if (bc_q == LAST_BIT) begin
          st_d      = SH_GAP;
          t_len     = GAP_M1;
          frame_end = 1'b1;
        end else begin
          st_d = SH_LOW;
          sr_d = {sr_q[FRAME_BITS-2:0], 1'b0};
          bc_d = bc_q + 1'b1;
        end
      end
      SH_GAP: if (t_zero) st_d = SH_IDLE;
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SH_IDLE;
      sr_q <= '0;
      bc_q <= '0;
    end else begin
      st_q <= st_d;
      sr_q <= sr_d;
      bc_q <= bc_d;
    end
  end

  assign ready    = (st_q == SH_IDLE);
  assign ser_en_n = !((st_q == SH_OPEN) || (st_q == SH_LOW) || (st_q == SH_HIGH));
  assign ser_clk  = (st_q != SH_LOW);
  assign ser_dat  = ((st_q == SH_LOW) || (st_q == SH_HIGH)) ? sr_q[FRAME_BITS-1] : 1'b0;

  assert_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_en_n) |-> (ser_clk && !ser_dat));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en_n && ser_clk && $past(!ser_en_n && ser_clk)) |-> $stable(ser_dat));

  assert_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en_n) |-> (ser_clk && !ser_dat && $past(frame_end)));

endmodule

// File: rtl/pps_script.sv
module pps_script
  import pps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_up,
  input  logic                  load_dn,
  input  logic                  advance,
  output logic [FRAME_BITS-1:0] word,
  output logic                  last
);
  logic [IDX_W-1:0] idx_q, idx_d, end_q, end_d;

  always_comb begin
    idx_d = idx_q;
    end_d = end_q;
    if (load_up) begin
      idx_d = UP_FIRST;
      end_d = UP_LAST;
    end else if (load_dn) begin
      idx_d = DN_FIRST;
      end_d = DN_LAST;
    end else if (advance) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      end_q <= '0;
    end else begin
      idx_q <= idx_d;
      end_q <= end_d;
    end
  end

  assign word = script_word(idx_q);
  assign last = (idx_q == end_q);

  assert_inrange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(SCRIPT_LEN));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic cmd_off,
  output logic busy,
  output logic done,
  output logic ser_en_n,
  output logic ser_clk,
  output logic ser_dat
);
  logic busy_q, busy_d, pend_q, pend_d, done_q, done_d;
  logic accept, load_up, load_dn, advance, start;
  logic sh_ready, frame_end, last;
  logic [FRAME_BITS-1:0] word;

  assign accept  = !busy_q && (cmd_on || cmd_off);
  assign load_up = accept && cmd_on;
  assign load_dn = accept && !cmd_on;
  assign start   = pend_q && sh_ready;
  assign advance = frame_end && !last;

  pps_script u_script (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_up (load_up),
    .load_dn (load_dn),
    .advance (advance),
    .word    (word),
    .last    (last)
  );

  pps_shifter #(.DIV(DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word      (word),
    .ready     (sh_ready),
    .frame_end (frame_end),
    .ser_en_n  (ser_en_n),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat)
  );

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      pend_d = 1'b1;
    end
    if (start) pend_d = 1'b0;
    if (frame_end) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_on || cmd_off));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_on || cmd_off) && !frame_end) |=> busy);

  assert_done_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $rose(ser_en_n)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_en_n && ser_clk && !ser_dat));

endmodule

// File: tb/sim_panel_pwr_seq.sv
module sim_panel_pwr_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 1'b0;
  logic cmd_off = 1'b0;
  logic busy, done, ser_en_n, ser_clk, ser_dat;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int accepted = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q [0:255];
  int wr_p = 0;
  int rd_p = 0;

  panel_pwr_seq #(.DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .busy(busy), .done(done), .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] up_word(input int i);
    case (i)
      0: return 16'h051E;
      1: return 16'h055E;
      2: return 16'h078D;
      3: return 16'h1301;
      default: return 16'h055F;
    endcase
  endfunction

  function automatic int latency(input int n);
    return 1 + (n - 1) * (35 * D + 1) + 33 * D;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_up();
    for (int i = 0; i < 5; i++) begin exp_q[wr_p[7:0]] = up_word(i); wr_p++; end
    accepted++;
  endtask

  task automatic push_dn();
    exp_q[wr_p[7:0]] = 16'h055E; wr_p++;
    accepted++;
  endtask

  task automatic pulse(input bit on, input bit off);
    cmd_on = on; cmd_off = off;
    @(negedge clk);
    cmd_on = 1'b0; cmd_off = 1'b0;
  endtask

  task automatic wait_done(output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin at = cyc; break; end
      @(negedge clk);
    end
    if (at < 0) check(1'b0, "R11", "done never seen", 0, 1);
  endtask

  // Pin-level frame monitor
  int run = 0, hrun = 0, nbits = 0;
  bit phase_ok = 1'b1, gap_had_done = 1'b1, prev_en = 1'b1, prev_clk = 1'b1, mon_on = 1'b0;
  logic [15:0] cap = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) done_cnt++;
      if (prev_en && !ser_en_n) begin
        check(ser_clk && !ser_dat, "R3", "open levels clk/dat", {ser_clk, ser_dat}, 2);
        if (!gap_had_done) check(hrun == 2*D + 1, "R10", "gap inside script", hrun, 2*D + 1);
        else               check(hrun >= 2*D + 1, "R10", "gap between scripts", hrun, 2*D + 1);
        run = 1; nbits = 0; phase_ok = 1'b1; cap = '0;
      end else if (!ser_en_n) begin
        if (ser_clk == prev_clk) run++;
        else begin
          if (run != D) phase_ok = 1'b0;
          run = 1;
          if (ser_clk) begin cap = {cap[14:0], ser_dat}; nbits++; end
        end
      end else if (!prev_en && ser_en_n) begin
        if (run != D) phase_ok = 1'b0;
        check(phase_ok, "R3/R4", "phase lengths", run, D);
        check(ser_clk && !ser_dat, "R5", "close levels clk/dat", {ser_clk, ser_dat}, 2);
        check(nbits == 16, "R1", "bit count", nbits, 16);
        if (rd_p >= wr_p) check(1'b0, "R9", "unexpected frame", cap, 0);
        else begin
          check(cap == exp_q[rd_p[7:0]], "R1/R6/R7", "frame word", cap, exp_q[rd_p[7:0]]);
          rd_p++;
        end
        hrun = 1; gap_had_done = done;
      end else begin
        hrun++;
        if (done) gap_had_done = 1'b1;
      end
      prev_en = ser_en_n; prev_clk = ser_clk;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int a, at, rv, kind, k;
    rv = $urandom(32'd19);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_en_n && ser_clk && !ser_dat, "R2", "reset line levels", {ser_en_n, ser_clk, ser_dat}, 6);
    check(!busy && !done, "R2", "reset busy/done", {busy, done}, 0);
    mon_on = 1'b1;
    repeat (5) @(negedge clk);

    // power-up from idle, ignored off pulse mid-script
    push_up(); a = cyc; pulse(1'b1, 1'b0);
    check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    repeat (100) @(negedge clk);
    pulse(1'b0, 1'b1);
    wait_done(at);
    check(at == a + 1 + latency(5), "R11", "power-up latency", at - a - 1, latency(5));
    check(!busy, "R11", "busy falls with done", busy, 0);
    @(negedge clk);
    check(!done, "R11", "done one cycle", done, 0);
    repeat (20) @(negedge clk);

    // power-down from idle
    push_dn(); a = cyc; pulse(1'b0, 1'b1);
    wait_done(at);
    check(at == a + 1 + latency(1), "R11", "power-down latency", at - a - 1, latency(1));
    repeat (20) @(negedge clk);

    // both commands together: power-up wins
    push_up(); a = cyc; pulse(1'b1, 1'b1);
    wait_done(at);
    check(at == a + 1 + latency(5), "R8", "both cmds run power-up", at - a - 1, latency(5));

    // back-to-back: command on the done cycle
    push_dn(); pulse(1'b0, 1'b1);
    wait_done(at);
    repeat (20) @(negedge clk);

    // random mix
    for (int it = 0; it < 12; it++) begin
      kind = $urandom_range(0, 2);
      a = cyc;
      if (kind == 0) begin push_dn(); pulse(1'b0, 1'b1); end
      else if (kind == 1) begin push_up(); pulse(1'b1, 1'b0); end
      else begin push_up(); pulse(1'b1, 1'b1); end
      k = $urandom_range(2, 60);
      repeat (k) @(negedge clk);
      pulse($urandom_range(0, 1) == 1, 1'b1);
      wait_done(at);
      check(at == a + 1 + latency(kind == 0 ? 1 : 5), "R11", "random latency",
            at - a - 1, latency(kind == 0 ? 1 : 5));
      repeat ($urandom_range(10, 40)) @(negedge clk);
    end

    repeat (30) @(negedge clk);
    check(rd_p == wr_p, "R9", "all expected frames seen", rd_p, wr_p);
    check(done_cnt == accepted, "R9", "done pulse count", done_cnt, accepted);
    check(ser_en_n && ser_clk && !ser_dat && !busy, "R2", "idle after scripts",
          {ser_en_n, ser_clk, ser_dat, busy}, 12);
    finish_run();
  end

endmodule